// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block decides, cycle by cycle, whether the system clock and the low-frequency timing clock are enabled. It moves between a running state and two sleep states: a light sleep that stops the system clock and a deep sleep that normally stops both clocks. A mode-entry command from the CPU puts it to sleep. A wake event brings it back through a settle phase, which holds the system clock off for a programmable number of low-frequency ticks before the system clock runs again.

Four sources can cause a wake: a pending interrupt, a watchdog overflow, a timer overflow, and a falling edge on any bit of an 8-bit port. The port edge is found by comparing each sample with the one taken in the cycle before. That previous sample is taken on the entry edge, so a pin that is already low at entry does not cause a wake. A configuration bit keeps the low-frequency clock alive in light sleep. In deep sleep, either that bit or the watchdog enable keeps it alive. The mode and both enables come from registers and change on the clock edge that samples the cause.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: Reset is synchronous and active high. During and after reset, mode reads RUN (encoding 2'b00) and sys_clk_en and lf_clk_en are both 1.
- R2: In RUN both enables are 1. Mode encodings are RUN 2'b00, LIGHT 2'b01, DEEP 2'b10, SETTLE 2'b11. With no wake source active, idle_req moves the block to LIGHT on the next edge and halt_req moves it to DEEP. When both are high, halt_req wins.
- R3: In LIGHT, sys_clk_en is 0 and lf_clk_en equals keep_lf as sampled on the same edge. wdt_en has no effect in LIGHT.
- R4: In DEEP, sys_clk_en is 0 and lf_clk_en equals keep_lf OR wdt_en as sampled on the same edge. Both enables are 0 when both bits are 0.
- R5: In LIGHT or DEEP, a high irq_pend, wdt_ovf or tmr_ovf moves the block to SETTLE on the next edge. In SETTLE, sys_clk_en is 0 and lf_clk_en is 1.
- R6: A port bit that was 1 in the previous cycle and is 0 in the current cycle wakes the block from LIGHT or DEEP, just like R5. A low level already present at entry does not wake it, and neither does a rising edge.
- R7: settle_len is captured on the wake edge, and the value 0 counts as 1. The block returns to RUN with sys_clk_en at 1 on the edge that samples the settle_len-th lf_tick pulse seen in SETTLE. Without a tick the block stays in SETTLE, and a later change to settle_len has no effect.
- R8: In RUN, an entry command is ignored when any wake source is active in the same cycle, and this includes a port falling edge.
- R9: Entry commands have no effect in LIGHT, DEEP or SETTLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| lf_tick | input | 1 | One-cycle strobe per low-frequency clock period |
| idle_req | input | 1 | Command to enter light sleep |
| halt_req | input | 1 | Command to enter deep sleep |
| keep_lf | input | 1 | Keep the low-frequency clock running while asleep |
| wdt_en | input | 1 | Watchdog enabled; keeps the low-frequency clock running in deep sleep |
| irq_pend | input | 1 | Any interrupt request pending |
| port_in | input | 8 | Port pins watched for falling edges |
| wdt_ovf | input | 1 | Watchdog overflow |
| tmr_ovf | input | 1 | Timer overflow flag set |
| settle_len | input | 8 | Settle length in low-frequency ticks (0 is taken as 1) |
| sys_clk_en | output | 1 | System clock enable |
| lf_clk_en | output | 1 | Low-frequency clock enable |
| mode | output | 2 | Current mode |

## Verification
Each result is due on the first rising edge that samples its cause: a mode change, a new enable value after a change of keep_lf or wdt_en, a wake, and the return to RUN on the last settle tick. Nothing in the block adds a further delay. The bench changes inputs on the falling edge. It updates its reference model on the rising edge, using the inputs that edge saw, and compares the outputs one time unit later, so every comparison looks at the edge the requirement names. The directed sequences make known inputs stand for several cycles and compare again after each step. This shows that the port history, the captured settle length and the no-effect cases did not change the state.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    MODE_RUN    = 2'b00,
    MODE_LIGHT  = 2'b01,
    MODE_DEEP   = 2'b10,
    MODE_SETTLE = 2'b11
  } lpm_mode_e;

endpackage

// File: rtl/lpm_wake_detect.sv
module lpm_wake_detect #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] port_in,
  input  logic              irq_pend,
  input  logic              wdt_ovf,
  input  logic              tmr_ovf,
  output logic              port_fall,
  output logic              wake_any
);

  logic [PORT_W-1:0] port_q;
  logic [PORT_W-1:0] fall_bit;

  // previous-cycle sample; the entry edge also refreshes it
  always_ff @(posedge clk) begin
    if (rst) port_q <= '0;
    else     port_q <= port_in;
  end

  for (genvar b = 0; b < PORT_W; b++) begin : g_fall
    assign fall_bit[b] = port_q[b] & ~port_in[b];
  end

  assign port_fall = |fall_bit;
  assign wake_any  = port_fall | irq_pend | wdt_ovf | tmr_ovf;

endmodule

// File: rtl/lpm_settle_timer.sv
module lpm_settle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  input  logic             active,
  input  logic             tick,
  output logic             done
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len_eff;

  assign len_eff = (len == '0) ? ONE : len;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= ONE;
    end else if (load) begin
      cnt <= len_eff;
    end else if (active && tick && (cnt > ONE)) begin
      cnt <= cnt - ONE;
    end
  end

  assign done = active & tick & (cnt == ONE);

endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      idle_req,
  input  logic      halt_req,
  input  logic      wake_any,
  input  logic      settle_done,
  output lpm_mode_e mode,
  output lpm_mode_e mode_nxt,
  output logic      settle_load
);

  always_comb begin
    mode_nxt    = mode;
    settle_load = 1'b0;
    unique case (mode)
      MODE_RUN: begin
        if (!wake_any) begin
          if (halt_req)      mode_nxt = MODE_DEEP;
          else if (idle_req) mode_nxt = MODE_LIGHT;
        end
      end
      MODE_LIGHT, MODE_DEEP: begin
        if (wake_any) begin
          mode_nxt    = MODE_SETTLE;
          settle_load = 1'b1;
        end
      end
      MODE_SETTLE: begin
        if (settle_done) mode_nxt = MODE_RUN;
      end
      default: mode_nxt = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mode <= MODE_RUN;
    else     mode <= mode_nxt;
  end

endmodule

// File: rtl/lpm_clk_en_decode.sv
module lpm_clk_en_decode
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  lpm_mode_e mode_nxt,
  input  logic      keep_lf,
  input  logic      wdt_en,
  output logic      sys_clk_en,
  output logic      lf_clk_en
);

  logic sys_d;
  logic lf_d;

  always_comb begin
    sys_d = 1'b0;
    lf_d  = 1'b1;
    unique case (mode_nxt)
      MODE_RUN:    begin sys_d = 1'b1; lf_d = 1'b1;              end
      MODE_LIGHT:  begin sys_d = 1'b0; lf_d = keep_lf;           end
      MODE_DEEP:   begin sys_d = 1'b0; lf_d = keep_lf | wdt_en;  end
      MODE_SETTLE: begin sys_d = 1'b0; lf_d = 1'b1;              end
      default:     begin sys_d = 1'b1; lf_d = 1'b1;              end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_clk_en <= 1'b1;
      lf_clk_en  <= 1'b1;
    end else begin
      sys_clk_en <= sys_d;
      lf_clk_en  <= lf_d;
    end
  end

endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
  import lpm_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lf_tick,
  input  logic              idle_req,
  input  logic              halt_req,
  input  logic              keep_lf,
  input  logic              wdt_en,
  input  logic              irq_pend,
  input  logic [PORT_W-1:0] port_in,
  input  logic              wdt_ovf,
  input  logic              tmr_ovf,
  input  logic [CNT_W-1:0]  settle_len,
  output logic              sys_clk_en,
  output logic              lf_clk_en,
  output logic [1:0]        mode
);

  logic      port_fall;
  logic      wake_any;
  logic      settle_done;
  logic      settle_load;
  lpm_mode_e mode_q;
  lpm_mode_e mode_nxt;

  lpm_wake_detect #(.PORT_W(PORT_W)) u_wake (
    .clk       (clk),
    .rst       (rst),
    .port_in   (port_in),
    .irq_pend  (irq_pend),
    .wdt_ovf   (wdt_ovf),
    .tmr_ovf   (tmr_ovf),
    .port_fall (port_fall),
    .wake_any  (wake_any)
  );

  lpm_mode_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .idle_req    (idle_req),
    .halt_req    (halt_req),
    .wake_any    (wake_any),
    .settle_done (settle_done),
    .mode        (mode_q),
    .mode_nxt    (mode_nxt),
    .settle_load (settle_load)
  );

  lpm_settle_timer #(.CNT_W(CNT_W)) u_settle (
    .clk    (clk),
    .rst    (rst),
    .load   (settle_load),
    .len    (settle_len),
    .active (mode_q == MODE_SETTLE),
    .tick   (lf_tick),
    .done   (settle_done)
  );

  lpm_clk_en_decode u_dec (
    .clk        (clk),
    .rst        (rst),
    .mode_nxt   (mode_nxt),
    .keep_lf    (keep_lf),
    .wdt_en     (wdt_en),
    .sys_clk_en (sys_clk_en),
    .lf_clk_en  (lf_clk_en)
  );

  assign mode = mode_q;

endmodule

// File: rtl/lpm_clk_ctrl_chk.sv
module lpm_clk_ctrl_chk #(
  parameter int PORT_W = 8,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              lf_tick,
  input logic              idle_req,
  input logic              halt_req,
  input logic              keep_lf,
  input logic              wdt_en,
  input logic              irq_pend,
  input logic [PORT_W-1:0] port_in,
  input logic              wdt_ovf,
  input logic              tmr_ovf,
  input logic [CNT_W-1:0]  settle_len,
  input logic              sys_clk_en,
  input logic              lf_clk_en,
  input logic [1:0]        mode
);

  localparam logic [1:0] M_RUN = 2'b00;
  localparam logic [1:0] M_LIGHT = 2'b01;
  localparam logic [1:0] M_DEEP = 2'b10;
  localparam logic [1:0] M_SETTLE = 2'b11;

  // R2
  run_en_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == M_RUN) |-> (sys_clk_en && lf_clk_en));

  // R3
  light_lf_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == M_LIGHT && $past(mode) == M_LIGHT) |->
      (!sys_clk_en && lf_clk_en == $past(keep_lf)));

  // R4
  deep_lf_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == M_DEEP && $past(mode) == M_DEEP) |->
      (!sys_clk_en && lf_clk_en == ($past(keep_lf) | $past(wdt_en))));

  // R5
  wake_exit_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode == M_LIGHT || mode == M_DEEP) && (irq_pend || wdt_ovf || tmr_ovf))
      |=> (mode == M_SETTLE && !sys_clk_en && lf_clk_en));

  // R7
  settle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == M_SETTLE && !lf_tick) |=> (mode == M_SETTLE));

  // R8
  blocked_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == M_RUN && (idle_req || halt_req) && (irq_pend || wdt_ovf || tmr_ovf))
      |=> (mode == M_RUN));

  // R9
  sleep_path_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == M_LIGHT || $past(mode) == M_DEEP) |->
      (mode == $past(mode) || mode == M_SETTLE));

endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk #(.PORT_W(PORT_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lf_tick    (lf_tick),
  .idle_req   (idle_req),
  .halt_req   (halt_req),
  .keep_lf    (keep_lf),
  .wdt_en     (wdt_en),
  .irq_pend   (irq_pend),
  .port_in    (port_in),
  .wdt_ovf    (wdt_ovf),
  .tmr_ovf    (tmr_ovf),
  .settle_len (settle_len),
  .sys_clk_en (sys_clk_en),
  .lf_clk_en  (lf_clk_en),
  .mode       (mode)
);

// File: tb/sim_lpm_clk_ctrl.sv
`timescale 1ns/1ps
module sim_lpm_clk_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  localparam logic [1:0] M_RUN = 2'b00;
  localparam logic [1:0] M_LIGHT = 2'b01;
  localparam logic [1:0] M_DEEP = 2'b10;
  localparam logic [1:0] M_SETTLE = 2'b11;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lf_tick = 1'b0, idle_req = 1'b0, halt_req = 1'b0;
  logic       keep_lf = 1'b0, wdt_en = 1'b0, irq_pend = 1'b0;
  logic [7:0] port_in = 8'h00;
  logic       wdt_ovf = 1'b0, tmr_ovf = 1'b0;
  logic [7:0] settle_len = 8'd0;
  logic       sys_clk_en, lf_clk_en;
  logic [1:0] mode;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // reference model state
  logic [1:0] em = M_RUN;
  logic [7:0] ecnt = 8'd1;
  logic [7:0] eprev = 8'h00;
  logic       esys = 1'b1, elf = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpm_clk_ctrl u0 (
    .clk(clk), .rst(rst), .lf_tick(lf_tick), .idle_req(idle_req),
    .halt_req(halt_req), .keep_lf(keep_lf), .wdt_en(wdt_en),
    .irq_pend(irq_pend), .port_in(port_in), .wdt_ovf(wdt_ovf),
    .tmr_ovf(tmr_ovf), .settle_len(settle_len), .sys_clk_en(sys_clk_en),
    .lf_clk_en(lf_clk_en), .mode(mode)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string mode_tag(input logic [1:0] prev, input logic [1:0] nxt);
    if (prev == M_RUN)                        return "R2";
    if (prev == M_SETTLE)                     return "R7";
    if (nxt == M_SETTLE)                      return "R5";
    return "R9";
  endfunction

  function automatic string en_tag(input logic [1:0] m);
    case (m)
      M_LIGHT: return "R3";
      M_DEEP:  return "R4";
      M_SETTLE: return "R5";
      default: return "R2";
    endcase
  endfunction

  // one clock: model update on the edge, compare one unit later, return on negedge
  task automatic cyc();
    logic       wake;
    logic [1:0] prev;
    @(posedge clk);
    prev = em;
    wake = irq_pend | wdt_ovf | tmr_ovf | (|(eprev & ~port_in));
    case (em)
      M_RUN: begin
        if (!wake) begin
          if (halt_req)      em = M_DEEP;
          else if (idle_req) em = M_LIGHT;
        end
      end
      M_LIGHT, M_DEEP: begin
        if (wake) begin
          em   = M_SETTLE;
          ecnt = (settle_len == 8'd0) ? 8'd1 : settle_len;
        end
      end
      default: begin
        if (lf_tick) begin
          if (ecnt == 8'd1) em = M_RUN;
          else              ecnt = ecnt - 8'd1;
        end
      end
    endcase
    eprev = port_in;
    esys  = (em == M_RUN);
    case (em)
      M_LIGHT: elf = keep_lf;
      M_DEEP:  elf = keep_lf | wdt_en;
      default: elf = 1'b1;
    endcase
    #1;
    chk(mode_tag(prev, em), "mode", int'(mode), int'(em));
    chk(en_tag(em), "sys_clk_en", int'(sys_clk_en), int'(esys));
    chk(en_tag(em), "lf_clk_en", int'(lf_clk_en), int'(elf));
    @(negedge clk);
  endtask

  task automatic expect_state(input string tag, input logic [1:0] m,
                              input logic s, input logic l);
    chk(tag, "mode", int'(mode), int'(m));
    chk(tag, "sys_clk_en", int'(sys_clk_en), int'(s));
    chk(tag, "lf_clk_en", int'(lf_clk_en), int'(l));
  endtask

  task automatic clear_strobes();
    idle_req = 1'b0; halt_req = 1'b0; irq_pend = 1'b0;
    wdt_ovf = 1'b0; tmr_ovf = 1'b0; lf_tick = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      fails++;
      $display("FAIL watchdog R1 actual=%0d expected<=%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    int seed_val;
    seed_val = $urandom(32'd20240611);
    // reset, R1
    repeat (3) @(negedge clk);
    #1 expect_state("R1", M_RUN, 1'b1, 1'b1);
    @(negedge clk);
    rst = 1'b0;
    cyc();
    expect_state("R1", M_RUN, 1'b1, 1'b1);

    // R8: entry blocked by a port fall in the same cycle
    port_in = 8'hF0; cyc();
    idle_req = 1'b1; port_in = 8'h70; cyc();
    expect_state("R8", M_RUN, 1'b1, 1'b1);
    cyc(); // idle_req still high, no fall now
    expect_state("R2", M_LIGHT, 1'b0, 1'b0);
    idle_req = 1'b0;
    // R6: bit 7 already low on entry, no wake
    repeat (3) cyc();
    expect_state("R6", M_LIGHT, 1'b0, 1'b0);
    port_in = 8'hF0; cyc();
    expect_state("R6", M_LIGHT, 1'b0, 1'b0); // rising edge ignored
    settle_len = 8'd0;
    port_in = 8'hE0; cyc();
    expect_state("R6", M_SETTLE, 1'b0, 1'b1);
    cyc();
    expect_state("R7", M_SETTLE, 1'b0, 1'b1); // no tick yet
    lf_tick = 1'b1; cyc(); lf_tick = 1'b0;
    expect_state("R7", M_RUN, 1'b1, 1'b1);    // length 0 counts as one tick

    // R8 with interrupt, then R4
    irq_pend = 1'b1; halt_req = 1'b1; cyc();
    expect_state("R8", M_RUN, 1'b1, 1'b1);
    irq_pend = 1'b0; keep_lf = 1'b0; wdt_en = 1'b0; cyc();
    halt_req = 1'b0;
    expect_state("R4", M_DEEP, 1'b0, 1'b0);
    wdt_en = 1'b1; cyc();
    expect_state("R4", M_DEEP, 1'b0, 1'b1);
    idle_req = 1'b1; cyc(); idle_req = 1'b0;
    expect_state("R9", M_DEEP, 1'b0, 1'b1);
    settle_len = 8'd3; tmr_ovf = 1'b1; cyc(); tmr_ovf = 1'b0;
    expect_state("R5", M_SETTLE, 1'b0, 1'b1);
    settle_len = 8'd1;
    lf_tick = 1'b1; idle_req = 1'b1; cyc(); cyc();
    expect_state("R9", M_SETTLE, 1'b0, 1'b1);
    idle_req = 1'b0; cyc(); lf_tick = 1'b0;
    expect_state("R7", M_RUN, 1'b1, 1'b1);

    // R3: watchdog enable ignored in light sleep
    wdt_en = 1'b1; keep_lf = 1'b0; idle_req = 1'b1; cyc(); idle_req = 1'b0;
    expect_state("R3", M_LIGHT, 1'b0, 1'b0);
    keep_lf = 1'b1; cyc();
    expect_state("R3", M_LIGHT, 1'b0, 1'b1);
    settle_len = 8'd255; wdt_ovf = 1'b1; cyc(); wdt_ovf = 1'b0;
    expect_state("R5", M_SETTLE, 1'b0, 1'b1);
    lf_tick = 1'b1;
    repeat (254) cyc();
    expect_state("R7", M_SETTLE, 1'b0, 1'b1);
    cyc(); lf_tick = 1'b0;
    expect_state("R7", M_RUN, 1'b1, 1'b1);

    // R2: both commands, deep wins
    idle_req = 1'b1; halt_req = 1'b1; cyc(); clear_strobes();
    expect_state("R2", M_DEEP, 1'b0, 1'b1);
    irq_pend = 1'b1; cyc(); irq_pend = 1'b0;
    expect_state("R5", M_SETTLE, 1'b0, 1'b1);

    // constrained random phase, checked every cycle by the model
    for (int i = 0; i < 4000; i++) begin
      idle_req = ($urandom % 8) == 0;
      halt_req = ($urandom % 10) == 0;
      irq_pend = ($urandom % 25) == 0;
      wdt_ovf  = ($urandom % 50) == 0;
      tmr_ovf  = ($urandom % 50) == 0;
      lf_tick  = ($urandom % 3) == 0;
      if (($urandom % 12) == 0) port_in = port_in ^ (8'h01 << ($urandom % 8));
      if (($urandom % 30) == 0) keep_lf = ~keep_lf;
      if (($urandom % 30) == 0) wdt_en = ~wdt_en;
      settle_len = 8'($urandom % 6);
      cyc();
    end
    clear_strobes();
    cyc();
    finish_run();
  end

endmodule